// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block owns the fetch address pair of a 32-bit processor with one branch delay slot. It holds the address of the instruction now being issued (`pc_o`) and the address that will follow it (`npc_o`). For each instruction it is given the instruction word and the values of its two source registers. From these it decides whether the instruction is a taken control transfer. It also computes the destination, says whether the return address must be written to register 31, and gives that return address.

The pair advances only when `step_i` is high. On every advance the current address takes the old following address. This is what makes the instruction after a branch (the delay slot) run before the branch destination. The following address then becomes either the transfer destination or itself plus 4. Conditional branches take their offset from the address of the delay-slot instruction (current address + 4). Absolute jumps keep the top four bits of that same address. A register jump whose destination is not word aligned raises an address-error flag when that check is built in. Instruction storage and the register file sit outside the block.

Top module: `npc_unit`

## Requirements
- R1: After reset, `pc_o` equals the RESET_VEC parameter and `npc_o` equals RESET_VEC + 4.
- R2: On a step with an instruction that is not a taken transfer, `taken_o` is 0, `pc_o` becomes the old `npc_o` and `npc_o` becomes the old `npc_o` + 4.
- R3: Major opcode 0x04 (equal) and 0x05 (not equal) compare rs with rt. When taken, the destination is `pc_o` + 4 + (sign-extended imm[15:0] << 2).
- R4: Major opcode 0x06 is taken when rs <= 0, and 0x07 is taken when rs > 0. Both compare as signed two's complement.
- R5: Major opcode 0x01 is decoded by the rt field (bits 20:16). 0x00 takes when rs < 0, 0x01 takes when rs >= 0, 0x10 and 0x11 do the same tests and also link. Any other rt value is not a transfer.
- R6: A branch offset with imm[15] set moves the destination backwards (for example, imm 0xFFFE gives `pc_o` + 4 - 8).
- R7: Major opcodes 0x02 and 0x03 are always taken, to {(`pc_o`+4)[31:28], instr[25:0], 2'b00}.
- R8: Major opcode 0 with funct (bits 5:0) 0x08 and bits 20:6 zero is always taken to rs. If rs[1:0] is nonzero, `addr_err_o` is 1.
- R9: `link_val_o` is always `pc_o` + 8. `link_we_o` is 1 for opcode 0x03, and for REGIMM rt 0x10/0x11 only when that branch is taken. Otherwise it is 0.
- R10: After a taken step, `pc_o` is the delay-slot address (old `npc_o`) and `npc_o` is the destination. The next step then moves `pc_o` to the destination.
- R11: While `step_i` is low, `pc_o` and `npc_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance the address pair this cycle |
| instr_i | input | 32 | Instruction at `pc_o` |
| rs_val_i | input | ADDR_W | Value of source register rs |
| rt_val_i | input | ADDR_W | Value of source register rt |
| pc_o | output | ADDR_W | Address of the current instruction |
| npc_o | output | ADDR_W | Address of the following instruction |
| taken_o | output | 1 | Current instruction is a taken transfer |
| link_we_o | output | 1 | Write `link_val_o` to register 31 |
| link_val_o | output | ADDR_W | Return address, `pc_o` + 8 |
| addr_err_o | output | 1 | Register-jump destination is misaligned |

## Verification
The bench builds the unit with a 32-bit address, a reset vector of 0xBFC00000 and the alignment check enabled. The high reset vector makes the top-four-bit splice of absolute jumps visible rather than all zero. With the check enabled, the misaligned register-jump flag can be observed. A register jump to 0xAFFFFFFC places an absolute jump where its delay slot falls into the next 256 MiB region. This shows that the splice uses the slot address and not the jump's own address.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam logic [5:0] OPC_SPECIAL = 6'h00;
   localparam logic [5:0] OPC_REGIMM  = 6'h01;
   localparam logic [5:0] OPC_JMP     = 6'h02;
   localparam logic [5:0] OPC_JMPL    = 6'h03;
   localparam logic [5:0] OPC_BREQ    = 6'h04;
   localparam logic [5:0] OPC_BRNE    = 6'h05;
   localparam logic [5:0] OPC_BRLEZ   = 6'h06;
   localparam logic [5:0] OPC_BRGTZ   = 6'h07;
   localparam logic [5:0] FN_JREG     = 6'h08;

   localparam logic [4:0] RI_LTZ      = 5'h00;
   localparam logic [4:0] RI_GEZ      = 5'h01;
   localparam logic [4:0] RI_LTZ_LNK  = 5'h10;
   localparam logic [4:0] RI_GEZ_LNK  = 5'h11;

   typedef enum logic [3:0] {
      XK_NONE,
      XK_EQ,
      XK_NE,
      XK_LEZ,
      XK_GTZ,
      XK_LTZ,
      XK_GEZ,
      XK_ABS,
      XK_REG
   } xfer_kind_e;

   typedef struct packed {
      xfer_kind_e   kind;
      logic         link;
      logic [15:0]  imm16;
      logic [25:0]  idx26;
   } xfer_dec_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [31:0] instr,
   output xfer_dec_t   dec
);

   logic [5:0] opc;
   logic [5:0] fn;
   logic [4:0] rtf;
   logic       jr_shape;

   assign opc      = instr[31:26];
   assign fn       = instr[5:0];
   assign rtf      = instr[20:16];
   assign jr_shape = (fn == FN_JREG) && (instr[20:6] == 15'd0);

   always_comb begin
      dec       = '0;
      dec.kind  = XK_NONE;
      dec.imm16 = instr[15:0];
      dec.idx26 = instr[25:0];
      unique case (opc)
         OPC_SPECIAL: begin
            if (jr_shape) dec.kind = XK_REG;
         end
         OPC_REGIMM: begin
            unique case (rtf)
               RI_LTZ:     dec.kind = XK_LTZ;
               RI_GEZ:     dec.kind = XK_GEZ;
               RI_LTZ_LNK: begin
                  dec.kind = XK_LTZ;
                  dec.link = 1'b1;
               end
               RI_GEZ_LNK: begin
                  dec.kind = XK_GEZ;
                  dec.link = 1'b1;
               end
               default:    dec.kind = XK_NONE;
            endcase
         end
         OPC_JMP:   dec.kind = XK_ABS;
         OPC_JMPL: begin
            dec.kind = XK_ABS;
            dec.link = 1'b1;
         end
         OPC_BREQ:  dec.kind = XK_EQ;
         OPC_BRNE:  dec.kind = XK_NE;
         OPC_BRLEZ: dec.kind = XK_LEZ;
         OPC_BRGTZ: dec.kind = XK_GTZ;
         default:   dec.kind = XK_NONE;
      endcase
   end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  xfer_kind_e        kind,
   input  logic [ADDR_W-1:0] rs,
   input  logic [ADDR_W-1:0] rt,
   output logic              cond
);

   logic is_neg;
   logic is_zero;
   logic same;

   assign is_neg  = rs[ADDR_W-1];
   assign is_zero = (rs == '0);
   assign same    = (rs == rt);

   always_comb begin
      unique case (kind)
         XK_EQ:   cond = same;
         XK_NE:   cond = !same;
         XK_LEZ:  cond = is_neg || is_zero;
         XK_GTZ:  cond = !is_neg && !is_zero;
         XK_LTZ:  cond = is_neg;
         XK_GEZ:  cond = !is_neg;
         XK_ABS:  cond = 1'b1;
         XK_REG:  cond = 1'b1;
         default: cond = 1'b0;
      endcase
   end

endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int ALIGN_CHECK = 1
) (
   input  logic [ADDR_W-1:0] slot_pc,
   input  xfer_dec_t         dec,
   input  logic [ADDR_W-1:0] rs,
   output logic [ADDR_W-1:0] target,
   output logic              misaligned
);

   localparam int OFS_EXT  = ADDR_W - 18;
   localparam int REGION_B = ADDR_W - 28;

   logic [ADDR_W-1:0] br_ofs;
   logic [ADDR_W-1:0] br_dst;
   logic [ADDR_W-1:0] abs_dst;

   assign br_ofs  = {{OFS_EXT{dec.imm16[15]}}, dec.imm16, 2'b00};
   assign br_dst  = slot_pc + br_ofs;
   assign abs_dst = {slot_pc[ADDR_W-1 -: REGION_B], dec.idx26, 2'b00};

   always_comb begin
      unique case (dec.kind)
         XK_ABS:  target = abs_dst;
         XK_REG:  target = rs;
         default: target = br_dst;
      endcase
   end

   generate
      if (ALIGN_CHECK != 0) begin : g_align
         assign misaligned = (dec.kind == XK_REG) && (rs[1:0] != 2'b00);
      end else begin : g_noalign
         assign misaligned = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC   = 32'hBFC0_0000,
   parameter int                ALIGN_CHECK = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic [31:0]       instr_i,
   input  logic [ADDR_W-1:0] rs_val_i,
   input  logic [ADDR_W-1:0] rt_val_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] npc_o,
   output logic              taken_o,
   output logic              link_we_o,
   output logic [ADDR_W-1:0] link_val_o,
   output logic              addr_err_o
);

   localparam logic [ADDR_W-1:0] WORD   = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] LINK_D = ADDR_W'(8);

   generate
      if (ADDR_W < 30) begin : g_bad_width
         $error("npc_unit: ADDR_W must be at least 30");
      end
      if (ALIGN_CHECK != 0 && ALIGN_CHECK != 1) begin : g_bad_align
         $error("npc_unit: ALIGN_CHECK must be 0 or 1");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] npc_q;
   logic [ADDR_W-1:0] slot_pc;
   logic [ADDR_W-1:0] dst;
   logic [ADDR_W-1:0] npc_d;
   xfer_dec_t         dec;
   logic              cond;
   logic              is_xfer;
   logic              mis;

   assign slot_pc = pc_q + WORD;

   npc_decode u_dec (
      .instr (instr_i),
      .dec   (dec)
   );

   npc_cond #(.ADDR_W(ADDR_W)) u_cond (
      .kind (dec.kind),
      .rs   (rs_val_i),
      .rt   (rt_val_i),
      .cond (cond)
   );

   npc_target #(.ADDR_W(ADDR_W), .ALIGN_CHECK(ALIGN_CHECK)) u_tgt (
      .slot_pc    (slot_pc),
      .dec        (dec),
      .rs         (rs_val_i),
      .target     (dst),
      .misaligned (mis)
   );

   assign is_xfer = (dec.kind != XK_NONE) && cond;
   assign npc_d   = is_xfer ? dst : (npc_q + WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= RESET_VEC;
         npc_q <= RESET_VEC + WORD;
      end else if (step_i) begin
         pc_q  <= npc_q;
         npc_q <= npc_d;
      end
   end

   assign pc_o       = pc_q;
   assign npc_o      = npc_q;
   assign taken_o    = is_xfer;
   assign link_we_o  = is_xfer && dec.link;
   assign link_val_o = pc_q + LINK_D;
   assign addr_err_o = mis;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int                ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = 32'hBFC0_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] npc,
   input logic              taken,
   input logic              link_we,
   input logic [ADDR_W-1:0] link_val,
   input logic              addr_err
);

   // R1
   reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pc == RESET_VEC) && (npc == RESET_VEC + ADDR_W'(4)));

   // R11
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(pc) && $stable(npc));

   // R10
   slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> pc == $past(npc));

   // R2
   seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !taken) |=> npc == $past(npc) + ADDR_W'(4));

   // R9
   link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> taken && (link_val == pc + ADDR_W'(8)));

   // R8
   err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> taken && !link_we);

endmodule

bind npc_unit npc_unit_chk #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .step     (step_i),
   .pc       (pc_o),
   .npc      (npc_o),
   .taken    (taken_o),
   .link_we  (link_we_o),
   .link_val (link_val_o),
   .addr_err (addr_err_o)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;

   localparam int          CLK_P = 10;
   localparam logic [31:0] RVEC  = 32'hBFC0_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] rs_val_i = '0;
   logic [31:0] rt_val_i = '0;
   logic [31:0] pc_o, npc_o, link_val_o;
   logic        taken_o, link_we_o, addr_err_o;

   int total = 0;
   int bad   = 0;

   always #(CLK_P/2) clk = ~clk;

   npc_unit #(.ADDR_W(32), .RESET_VEC(RVEC), .ALIGN_CHECK(1)) uut (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .instr_i(instr_i),
      .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .pc_o(pc_o), .npc_o(npc_o),
      .taken_o(taken_o), .link_we_o(link_we_o), .link_val_o(link_val_o),
      .addr_err_o(addr_err_o)
   );

   typedef struct {
      string       req;
      logic        tk;
      logic        lk;
      logic        er;
      logic [31:0] lval;
      logic [31:0] pc_n;
      logic [31:0] npc_n;
   } exp_t;

   exp_t        sb[$];
   logic [31:0] mpc, mnpc;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic exp_t model(input logic [31:0] ins, input logic [31:0] rs,
                                  input logic [31:0] rt, input logic stp, input string req);
      exp_t        e;
      logic [31:0] slot, br, tgt;
      slot = mpc + 32'd4;
      br   = slot + {{14{ins[15]}}, ins[15:0], 2'b00};
      e.req = req; e.tk = 1'b0; e.lk = 1'b0; e.er = 1'b0;
      tgt = br;
      case (ins[31:26])
         6'h00: if (ins[5:0] == 6'h08 && ins[20:6] == 15'd0) begin
                   e.tk = 1'b1; tgt = rs; e.er = (rs[1:0] != 2'b00);
                end
         6'h01: case (ins[20:16])
                   5'h00: e.tk = rs[31];
                   5'h01: e.tk = !rs[31];
                   5'h10: begin e.tk = rs[31];  e.lk = e.tk; end
                   5'h11: begin e.tk = !rs[31]; e.lk = e.tk; end
                   default: e.tk = 1'b0;
                endcase
         6'h02: begin e.tk = 1'b1; tgt = {slot[31:28], ins[25:0], 2'b00}; end
         6'h03: begin e.tk = 1'b1; e.lk = 1'b1; tgt = {slot[31:28], ins[25:0], 2'b00}; end
         6'h04: e.tk = (rs == rt);
         6'h05: e.tk = (rs != rt);
         6'h06: e.tk = (rs == 0) || rs[31];
         6'h07: e.tk = (rs != 0) && !rs[31];
         default: e.tk = 1'b0;
      endcase
      e.lval = mpc + 32'd8;
      if (stp) begin
         e.pc_n  = mnpc;
         e.npc_n = e.tk ? tgt : mnpc + 32'd4;
      end else begin
         e.pc_n  = mpc;
         e.npc_n = mnpc;
      end
      return e;
   endfunction

   task automatic issue(input logic [31:0] ins, input logic [31:0] rs,
                        input logic [31:0] rt, input logic stp, input string req);
      exp_t e;
      @(negedge clk);
      instr_i = ins; rs_val_i = rs; rt_val_i = rt; step_i = stp;
      e = model(ins, rs, rt, stp, req);
      mpc  = e.pc_n;
      mnpc = e.npc_n;
      sb.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (sb.size() > 0) begin
            e = sb[0];
            chk(e.req, "taken", {31'd0, taken_o}, {31'd0, e.tk});
            chk(e.req, "link_we", {31'd0, link_we_o}, {31'd0, e.lk});
            chk(e.req, "addr_err", {31'd0, addr_err_o}, {31'd0, e.er});
            chk(e.req, "link_val", link_val_o, e.lval);
            @(posedge clk);
            #1;
            chk(e.req, "pc", pc_o, e.pc_n);
            chk(e.req, "npc", npc_o, e.npc_n);
            void'(sb.pop_front());
         end
      end
   end

   initial begin : watchdog
      #(CLK_P * 5000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "pc", pc_o, RVEC);
      chk("R1", "npc", npc_o, RVEC + 32'd4);
      mpc  = RVEC;
      mnpc = RVEC + 32'd4;

      issue(32'h0, 0, 0, 1'b1, "R2");                                   // plain advance
      issue(32'h0, 0, 0, 1'b0, "R11");                                  // hold
      issue(enc_i(6'h04, 5'd1, 5'd2, 16'd4), 32'h55, 32'h55, 1'b1, "R3");// eq taken
      issue(32'h0, 0, 0, 1'b1, "R10");                                  // delay slot
      issue(32'h0, 0, 0, 1'b1, "R10");                                  // arrive at target
      issue(enc_i(6'h05, 5'd1, 5'd2, 16'd9), 32'h7, 32'h7, 1'b1, "R3"); // ne not taken
      issue(enc_i(6'h05, 5'd1, 5'd2, 16'hFFFE), 32'h7, 32'h8, 1'b1, "R6"); // backwards
      issue(32'h0, 0, 0, 1'b1, "R10");
      issue(enc_i(6'h06, 5'd1, 5'd0, 16'd3), 32'h0, 0, 1'b1, "R4");      // lez on zero
      issue(enc_i(6'h07, 5'd1, 5'd0, 16'd3), 32'h0, 0, 1'b1, "R4");      // gtz on zero
      issue(enc_i(6'h07, 5'd1, 5'd0, 16'd3), 32'h8000_0000, 0, 1'b1, "R4");
      issue(enc_i(6'h06, 5'd1, 5'd0, 16'd3), 32'h8000_0000, 0, 1'b1, "R4");
      issue(enc_i(6'h07, 5'd1, 5'd0, 16'd2), 32'h0000_0001, 0, 1'b1, "R4");
      issue(enc_i(6'h01, 5'd1, 5'h00, 16'd5), 32'hFFFF_FFFF, 0, 1'b1, "R5");
      issue(enc_i(6'h01, 5'd1, 5'h01, 16'd5), 32'h0, 0, 1'b1, "R5");
      issue(enc_i(6'h01, 5'd1, 5'h10, 16'd6), 32'h8000_0001, 0, 1'b1, "R9");
      issue(enc_i(6'h01, 5'd1, 5'h11, 16'd6), 32'h8000_0001, 0, 1'b1, "R9");
      issue(enc_i(6'h01, 5'd1, 5'h11, 16'd6), 32'h1, 0, 1'b1, "R9");
      issue(enc_i(6'h01, 5'd1, 5'h02, 16'd6), 32'hF000_0000, 0, 1'b1, "R5");
      issue(enc_i(6'h01, 5'd1, 5'h10, 16'd6), 32'h0, 0, 1'b1, "R9");
      issue({6'h03, 26'h012_3456}, 0, 0, 1'b1, "R7");                    // jump and link
      issue(32'h0, 0, 0, 1'b1, "R10");
      issue({6'h00, 5'd3, 15'd0, 6'h08}, 32'hAFFF_FFFC, 0, 1'b1, "R8");  // register jump
      issue(32'h0, 0, 0, 1'b1, "R10");
      issue({6'h02, 26'h000_0010}, 0, 0, 1'b1, "R7");                    // slot in next region
      issue(32'h0, 0, 0, 1'b1, "R7");
      issue({6'h00, 5'd3, 15'd0, 6'h08}, 32'h0000_1002, 0, 1'b1, "R8");  // misaligned
      issue({6'h00, 5'd3, 5'd4, 10'd0, 6'h08}, 32'h0000_2000, 0, 1'b1, "R8"); // rt nonzero: not jr
      issue(32'h0, 0, 0, 1'b0, "R11");

      @(negedge clk);
      step_i = 1'b0;
      while (sb.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule